// File: doc/BRIEF.md
# DDR4 Command and Address Pin Encoder

This block sits between a memory controller's scheduler and the pad logic of a DDR4 interface. Each clock the scheduler presents one request: deselect, no-op, activate, read, write, precharge, refresh or mode-register set. With it come the bank group, the bank, a row value and a column value, plus a few per-command options. One clock later the block presents the chip-select, activate and shared address pin values that carry that request to the DRAM. All outputs are registered, so the pad logic sees clean values for the whole cycle.

The central job is the shared use of the three top address pins. During an activate they carry the upper row bits. For every other command they carry the row-strobe, column-strobe and write-enable code. On column commands the block also drives the auto-precharge bit and the burst-chop bit. The burst-chop bit follows a per-request choice only while on-the-fly burst length is enabled. Refresh scheduling, timing between commands and the physical I/O belong to other blocks.

Top module: `ddr4CaEncoder`

## Requirements
- R1: While reset is asserted, and at once when it is asserted, csN and actN are 1 and addrOut, bgOut and baOut are 0.
- R2: A request presented before a rising edge appears on the outputs after that edge. Any request other than deselect drives csN to 0 for that one output cycle only; a following deselect returns csN to 1.
- R3: Deselect (cmdIn=0) drives csN=1, actN=1, addrOut=0, bgOut=0 and baOut=0, whatever the other inputs hold.
- R4: Activate (cmdIn=2) drives csN=0 and actN=0 and puts all of rowIn on addrOut. This includes the three top pins, which here carry row bits and not a command code.
- R5: Every command except activate drives actN=1. The three top address pins addrOut[16:14] then carry {RAS,CAS,WE}: mode-register set 000, refresh 001, precharge 010, write 100, read 101, no-op 111.
- R6: Read (cmdIn=3) and write (cmdIn=4) put colIn on addrOut[9:0] and drive addrOut[11] and addrOut[13] to 0.
- R7: On read and write, addrOut[10] equals autoPreIn (1 requests auto-precharge).
- R8: On read and write with otfEnIn=1, addrOut[12] is 0 when chopIn=1 (burst-chop 4) and 1 when chopIn=0 (burst length 8). With otfEnIn=0, addrOut[12] is 1 whatever chopIn holds.
- R9: Precharge (cmdIn=5) puts allBanksIn on addrOut[10] (1 means all banks) and drives addrOut[9:0], addrOut[11], addrOut[12] and addrOut[13] to 0.
- R10: bgOut and baOut follow bgIn and baIn on activate, read, write and precharge. They are 0 on no-op (cmdIn=1) and refresh (cmdIn=6).
- R11: Mode-register set (cmdIn=7) puts rowIn[13:0] on addrOut[13:0] as the register opcode and passes bgIn and baIn as the register select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdIn | input | 3 | Request: 0 deselect, 1 no-op, 2 activate, 3 read, 4 write, 5 precharge, 6 refresh, 7 mode-register set |
| bgIn | input | BG_W | Bank group, or register select high bits for mode-register set |
| baIn | input | BA_W | Bank, or register select low bits for mode-register set |
| rowIn | input | ADDR_W | Row address for activate; low bits are the opcode for mode-register set |
| colIn | input | COL_W | Column address for read and write |
| autoPreIn | input | 1 | Auto-precharge request on read and write |
| chopIn | input | 1 | Burst-chop 4 request on read and write |
| otfEnIn | input | 1 | On-the-fly burst length is enabled in the device |
| allBanksIn | input | 1 | Precharge targets all banks |
| csN | output | 1 | Chip select, active low |
| actN | output | 1 | Activate, active low |
| addrOut | output | ADDR_W | Shared address and command pins |
| bgOut | output | BG_W | Bank group pins |
| baOut | output | BA_W | Bank address pins |

## Verification
The bench builds the block with its default parameters: a 17-pin address, a 10-bit column, and 2-bit bank group and bank fields. With these values the three top pins are the true dual-role pins, so one set of vectors shows them as row bits on activate and as command code on every other request. The 10-bit column ends just below the auto-precharge pin, and the burst-chop pin sits alone at position 12, so each option bit can be seen on its own. Inputs that are out of play, such as a full row on precharge or a full column on activate, are loaded with all ones so that any leak shows on the pins.

// File: rtl/ddrCaPkg.sv
`timescale 1ns/1ps
package ddrCaPkg;

  typedef enum logic [2:0] {
    CMD_DES = 3'd0,
    CMD_NOP = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6,
    CMD_MRS = 3'd7
  } caCmdE;

  // {RAS,CAS,WE} codes placed on the top three address pins
  localparam logic [2:0] PIN_MRS = 3'b000;
  localparam logic [2:0] PIN_REF = 3'b001;
  localparam logic [2:0] PIN_PRE = 3'b010;
  localparam logic [2:0] PIN_WR  = 3'b100;
  localparam logic [2:0] PIN_RD  = 3'b101;
  localparam logic [2:0] PIN_NOP = 3'b111;

  // strobes from decode control to the pin datapath
  typedef struct packed {
    logic       selLow;   // chip select active this cycle
    logic       actLow;   // activate pin active
    logic [2:0] pinCode;  // command code for top address pins
    logic       rowMode;  // address pins carry the row
    logic       colMode;  // column plus option bits
    logic       bankEn;   // bank group / bank pins driven
    logic       mrsMode;  // opcode on low address pins
    logic       preMode;  // all-bank flag on option pin
  } caStrobeT;

endpackage

// File: rtl/caCtrl.sv
`timescale 1ns/1ps
module caCtrl
  import ddrCaPkg::*;
(
  input  logic [2:0] cmdIn,
  output caStrobeT   strobe
);

  caCmdE cmd;
  assign cmd = caCmdE'(cmdIn);

  always_comb begin
    strobe = '0;
    unique case (cmd)
      CMD_DES: strobe = '0;
      CMD_NOP: begin
        strobe.selLow  = 1'b1;
        strobe.pinCode = PIN_NOP;
      end
      CMD_ACT: begin
        strobe.selLow  = 1'b1;
        strobe.actLow  = 1'b1;
        strobe.rowMode = 1'b1;
        strobe.bankEn  = 1'b1;
      end
      CMD_RD: begin
        strobe.selLow  = 1'b1;
        strobe.pinCode = PIN_RD;
        strobe.colMode = 1'b1;
        strobe.bankEn  = 1'b1;
      end
      CMD_WR: begin
        strobe.selLow  = 1'b1;
        strobe.pinCode = PIN_WR;
        strobe.colMode = 1'b1;
        strobe.bankEn  = 1'b1;
      end
      CMD_PRE: begin
        strobe.selLow  = 1'b1;
        strobe.pinCode = PIN_PRE;
        strobe.preMode = 1'b1;
        strobe.bankEn  = 1'b1;
      end
      CMD_REF: begin
        strobe.selLow  = 1'b1;
        strobe.pinCode = PIN_REF;
      end
      CMD_MRS: begin
        strobe.selLow  = 1'b1;
        strobe.pinCode = PIN_MRS;
        strobe.mrsMode = 1'b1;
        strobe.bankEn  = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/caDatapath.sv
`timescale 1ns/1ps
module caDatapath
  import ddrCaPkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int COL_W    = 10,
  parameter int BG_W     = 2,
  parameter int BA_W     = 2,
  parameter int AP_BIT   = 10,
  parameter int BC_BIT   = 12,
  parameter int MRS_OP_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  caStrobeT          strobe,
  input  logic [ADDR_W-1:0] rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic [BG_W-1:0]   bgIn,
  input  logic [BA_W-1:0]   baIn,
  input  logic              autoPreIn,
  input  logic              chopIn,
  input  logic              otfEnIn,
  input  logic              allBanksIn,
  output logic              csN,
  output logic              actN,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BG_W-1:0]   bgOut,
  output logic [BA_W-1:0]   baOut
);

  localparam int CODE_W   = 3;
  localparam int CODE_LSB = ADDR_W - CODE_W;

  logic [ADDR_W-1:0] nextAddr;
  logic [BG_W-1:0]   nextBg;
  logic [BA_W-1:0]   nextBa;
  logic              burstPin;

  // BC4 is signalled low only while on-the-fly length is enabled
  assign burstPin = otfEnIn ? ~chopIn : 1'b1;

  always_comb begin
    nextAddr = '0;
    if (strobe.rowMode) begin
      nextAddr = rowIn;
    end else begin
      if (strobe.selLow)
        nextAddr[ADDR_W-1:CODE_LSB] = strobe.pinCode;
      if (strobe.colMode) begin
        nextAddr[COL_W-1:0] = colIn;
        nextAddr[AP_BIT]    = autoPreIn;
        nextAddr[BC_BIT]    = burstPin;
      end
      if (strobe.preMode)
        nextAddr[AP_BIT] = allBanksIn;
      if (strobe.mrsMode)
        nextAddr[MRS_OP_W-1:0] = rowIn[MRS_OP_W-1:0];
    end
  end

  assign nextBg = strobe.bankEn ? bgIn : '0;
  assign nextBa = strobe.bankEn ? baIn : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csN     <= 1'b1;
      actN    <= 1'b1;
      addrOut <= '0;
      bgOut   <= '0;
      baOut   <= '0;
    end else begin
      csN     <= ~strobe.selLow;
      actN    <= ~strobe.actLow;
      addrOut <= nextAddr;
      bgOut   <= nextBg;
      baOut   <= nextBa;
    end
  end

endmodule

// File: rtl/ddr4CaEncoder.sv
`timescale 1ns/1ps
module ddr4CaEncoder
  import ddrCaPkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int COL_W  = 10,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmdIn,
  input  logic [BG_W-1:0]   bgIn,
  input  logic [BA_W-1:0]   baIn,
  input  logic [ADDR_W-1:0] rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic              autoPreIn,
  input  logic              chopIn,
  input  logic              otfEnIn,
  input  logic              allBanksIn,
  output logic              csN,
  output logic              actN,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BG_W-1:0]   bgOut,
  output logic [BA_W-1:0]   baOut
);

  caStrobeT strobe;

  caCtrl uCtrl (
    .cmdIn  (cmdIn),
    .strobe (strobe)
  );

  caDatapath #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .BG_W   (BG_W),
    .BA_W   (BA_W)
  ) uPath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .rowIn      (rowIn),
    .colIn      (colIn),
    .bgIn       (bgIn),
    .baIn       (baIn),
    .autoPreIn  (autoPreIn),
    .chopIn     (chopIn),
    .otfEnIn    (otfEnIn),
    .allBanksIn (allBanksIn),
    .csN        (csN),
    .actN       (actN),
    .addrOut    (addrOut),
    .bgOut      (bgOut),
    .baOut      (baOut)
  );

endmodule

// File: rtl/ddr4CaEncoderChk.sv
`timescale 1ns/1ps
module ddr4CaEncoderChk
  import ddrCaPkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int COL_W  = 10,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmdIn,
  input logic [ADDR_W-1:0] rowIn,
  input logic [COL_W-1:0]  colIn,
  input logic              autoPreIn,
  input logic              otfEnIn,
  input logic              csN,
  input logic              actN,
  input logic [ADDR_W-1:0] addrOut,
  input logic [BG_W-1:0]   bgOut,
  input logic [BA_W-1:0]   baOut
);

  logic isCol;
  assign isCol = (cmdIn == CMD_RD) || (cmdIn == CMD_WR);

  // R2
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIn != CMD_DES) |=> !csN);

  // R3
  des_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIn == CMD_DES) |=> (csN && actN && addrOut == '0));

  // R4
  act_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIn == CMD_ACT) |=> (!actN && addrOut == $past(rowIn)));

  // R5
  act_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIn != CMD_ACT) |=> actN);

  // R5
  rd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIn == CMD_RD) |=> (addrOut[ADDR_W-1 -: 3] == 3'b101));

  // R6
  col_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isCol |=> (addrOut[COL_W-1:0] == $past(colIn)));

  // R7
  auto_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isCol |=> (addrOut[10] == $past(autoPreIn)));

  // R8
  otf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isCol && !otfEnIn) |=> addrOut[12]);

  // R10
  bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdIn == CMD_NOP) || (cmdIn == CMD_REF)) |=> (bgOut == '0 && baOut == '0));

endmodule

bind ddr4CaEncoder ddr4CaEncoderChk #(
  .ADDR_W (ADDR_W),
  .COL_W  (COL_W),
  .BG_W   (BG_W),
  .BA_W   (BA_W)
) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmdIn     (cmdIn),
  .rowIn     (rowIn),
  .colIn     (colIn),
  .autoPreIn (autoPreIn),
  .otfEnIn   (otfEnIn),
  .csN       (csN),
  .actN      (actN),
  .addrOut   (addrOut),
  .bgOut     (bgOut),
  .baOut     (baOut)
);

// File: tb/ddr4CaEncoder_test.sv
`timescale 1ns/1ps
module ddr4CaEncoder_test;

  localparam int NV = 14;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [1:0]  bg;
    logic [1:0]  ba;
    logic [16:0] row;
    logic [9:0]  col;
    logic        ap;
    logic        chop;
    logic        otf;
    logic        all;
    logic [22:0] exp;   // {csN, actN, bg, ba, addr}
  } vecT;

  localparam vecT VECS [NV] = '{
    '{3'd2, 2'd2, 2'd1, 17'h1ABCD, 10'h3FF, 1'b1, 1'b0, 1'b1, 1'b1, {1'b0, 1'b0, 2'd2, 2'd1, 17'h1ABCD}},
    '{3'd3, 2'd1, 2'd3, 17'h1FFFF, 10'h2A5, 1'b0, 1'b0, 1'b1, 1'b0, {1'b0, 1'b1, 2'd1, 2'd3, 17'h152A5}},
    '{3'd4, 2'd3, 2'd0, 17'h00000, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b0, {1'b0, 1'b1, 2'd3, 2'd0, 17'h107FF}},
    '{3'd3, 2'd0, 2'd2, 17'h00000, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0, {1'b0, 1'b1, 2'd0, 2'd2, 17'h15400}},
    '{3'd4, 2'd1, 2'd1, 17'h00000, 10'h155, 1'b0, 1'b0, 1'b0, 1'b0, {1'b0, 1'b1, 2'd1, 2'd1, 17'h11155}},
    '{3'd5, 2'd2, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b0, {1'b0, 1'b1, 2'd2, 2'd3, 17'h08000}},
    '{3'd5, 2'd1, 2'd0, 17'h00000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1, {1'b0, 1'b1, 2'd1, 2'd0, 17'h08400}},
    '{3'd6, 2'd3, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, {1'b0, 1'b1, 2'd0, 2'd0, 17'h04000}},
    '{3'd7, 2'd1, 2'd1, 17'h1F345, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, {1'b0, 1'b1, 2'd1, 2'd1, 17'h03345}},
    '{3'd1, 2'd3, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, {1'b0, 1'b1, 2'd0, 2'd0, 17'h1C000}},
    '{3'd0, 2'd3, 2'd3, 17'h1FFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, {1'b1, 1'b1, 2'd0, 2'd0, 17'h00000}},
    '{3'd2, 2'd0, 2'd0, 17'h00000, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, {1'b0, 1'b0, 2'd0, 2'd0, 17'h00000}},
    '{3'd2, 2'd1, 2'd2, 17'h1C000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, {1'b0, 1'b0, 2'd1, 2'd2, 17'h1C000}},
    '{3'd3, 2'd2, 2'd1, 17'h00000, 10'h3FF, 1'b0, 1'b1, 1'b1, 1'b0, {1'b0, 1'b1, 2'd2, 2'd1, 17'h143FF}}
  };

  function automatic string tagOf(input int i);
    case (i)
      0:  return "R4 R10 activate";
      1:  return "R5 R6 R8 read BL8";
      2:  return "R7 R8 write BC4 auto-precharge";
      3:  return "R8 read otf off";
      4:  return "R6 R8 write otf off";
      5:  return "R9 precharge single";
      6:  return "R9 precharge all";
      7:  return "R5 R10 refresh";
      8:  return "R11 mode-register set";
      9:  return "R5 R10 no-op";
      10: return "R3 deselect";
      11: return "R4 activate zero row";
      12: return "R4 activate top row bits";
      default: return "R6 R8 read BC4";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmdIn = 3'd0;
  logic [1:0]  bgIn = '0;
  logic [1:0]  baIn = '0;
  logic [16:0] rowIn = '0;
  logic [9:0]  colIn = '0;
  logic        autoPreIn = 1'b0;
  logic        chopIn = 1'b0;
  logic        otfEnIn = 1'b0;
  logic        allBanksIn = 1'b0;
  logic        csN;
  logic        actN;
  logic [16:0] addrOut;
  logic [1:0]  bgOut;
  logic [1:0]  baOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ddr4CaEncoder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdIn      (cmdIn),
    .bgIn       (bgIn),
    .baIn       (baIn),
    .rowIn      (rowIn),
    .colIn      (colIn),
    .autoPreIn  (autoPreIn),
    .chopIn     (chopIn),
    .otfEnIn    (otfEnIn),
    .allBanksIn (allBanksIn),
    .csN        (csN),
    .actN       (actN),
    .addrOut    (addrOut),
    .bgOut      (bgOut),
    .baOut      (baOut)
  );

  function automatic logic [22:0] pins();
    return {csN, actN, bgOut, baOut, addrOut};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input vecT v);
    cmdIn      = v.cmd;
    bgIn       = v.bg;
    baIn       = v.ba;
    rowIn      = v.row;
    colIn      = v.col;
    autoPreIn  = v.ap;
    chopIn     = v.chop;
    otfEnIn    = v.otf;
    allBanksIn = v.all;
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      finish();
    end
  end

  initial begin
    // R1: idle pins while held in reset
    repeat (3) @(negedge clk);
    check("R1 reset state", {9'd0, pins()}, {9'd0, 1'b1, 1'b1, 2'd0, 2'd0, 17'h0});
    rst_n = 1'b1;

    // vector table, one request per cycle, back to back
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check(tagOf(i), {9'd0, pins()}, {9'd0, VECS[i].exp});
    end

    // R2: chip select low for the single request cycle, then released
    drive(VECS[1]);
    @(negedge clk);
    check("R2 select asserted", {31'd0, csN}, 32'd0);
    drive(VECS[10]);
    @(negedge clk);
    check("R2 select released", {31'd0, csN}, 32'd1);

    // R1: reset asserted mid-operation clears pins at once
    drive(VECS[0]);
    @(negedge clk);
    check("R1 pre-reset activate", {31'd0, actN}, 32'd0);
    #5 rst_n = 1'b0;
    #1 check("R1 async reset", {9'd0, pins()}, {9'd0, 1'b1, 1'b1, 2'd0, 2'd0, 17'h0});
    @(negedge clk);
    check("R1 held in reset", {9'd0, pins()}, {9'd0, 1'b1, 1'b1, 2'd0, 2'd0, 17'h0});
    rst_n = 1'b1;
    drive(VECS[8]);
    @(negedge clk);
    check("R11 after reset", {9'd0, pins()}, {9'd0, VECS[8].exp});

    finished = 1'b1;
    finish();
  end

endmodule